// File: doc/BRIEF.md
# Platform System Control Port Block

This block is a byte-wide register file on a simple strobe bus. It answers one standalone control port at 0x092 and a window of ports from 0x800 up to and including 0x851. The ports at one address can behave in three ways. Some return fixed identification bytes and drop writes. Some take a write only as a trigger and produce a single-cycle pulse. Others hold control bits that software can write and read back. The held bits drive a soft-reset request, a little-endian mode flag and a drive-activity indicator. The pulses go to the two lock toggles of an external non-volatile memory.

Alongside the registers, the block remaps the address of an 8 MB I/O window into a 16-bit I/O-space address. A register bit chooses between two modes. In the flat mode the low 64 KB of the window are used as they are. In the sparse mode each 4 KB page of the window carries 32 bytes of I/O space. Writing the mode bit changes the remapping on the next cycle.

Reads are combinational: `rd_data` reflects `port_addr` while `rd_en` is high. Writes take effect at the rising clock edge where `wr_en` is sampled high. Reset is synchronous and active high.

Top module: `sysctl_port_block`

## Requirements
- R1: While `rst` is high at a clock edge, `soft_reset_o`, `le_mode_o`, `activity_o`, the control nibble at 0x81C, the map-type bit at 0x850, both lock pulses and `wr_err_o` all clear to 0.
- R2: A write to 0x092 sets `soft_reset_o` to data bit 0 and `le_mode_o` to data bit 1, starting with the cycle after the write edge. A read of 0x092 returns 0x00.
- R3: A write to 0x808 sets `activity_o` to data bit 0.
- R4: Any write to 0x810 raises `lock1_pulse_o`, and any write to 0x812 raises `lock2_pulse_o`, whatever the data. Each pulse is high for exactly the one cycle that follows the write edge.
- R5: A write to 0x81C stores data bits 3:0. A read of 0x81C returns the stored nibble in bits 3:0, with bits 7:4 zero.
- R6: A write to 0x850 stores data bit 0 as the map-type bit. A read of 0x850 returns that bit in bit 0, with bits 7:1 zero.
- R7: Reads return fixed bytes at these ports: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R8: A read of any other port in 0x800..0x851 returns 0xFF. This includes 0x808, 0x812, 0x814 and 0x851.
- R9: Writes to 0x800, 0x802, 0x803 and 0x814 change no output and no readable state, and they raise no error.
- R10: A write to any other port in 0x800..0x851 changes no state and pulses `wr_err_o` for one cycle. This includes 0x80C, 0x818, 0x823 and 0x851.
- R11: With the map-type bit at 0, `io_addr` equals `win_offset` bits 15:0.
- R12: With the map-type bit at 1, `io_addr` bits 4:0 equal `win_offset` bits 4:0, and `io_addr` bits 15:5 equal `win_offset` bits 22:12. The new mode applies from the cycle after the write edge.
- R13: Ports outside 0x092 and 0x800..0x851 are not claimed. Reads of them return 0x00, and writes to them change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read enable; gates `rd_data` |
| port_addr | input | PORT_AW (16) | I/O port address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational |
| soft_reset_o | output | 1 | Soft-reset request level |
| le_mode_o | output | 1 | Little-endian mode flag |
| activity_o | output | 1 | Drive-activity indicator |
| lock1_pulse_o | output | 1 | One-cycle toggle for memory lock 1 |
| lock2_pulse_o | output | 1 | One-cycle toggle for memory lock 2 |
| wr_err_o | output | 1 | One-cycle flag for a write to an undecoded port |
| win_offset | input | WIN_AW (23) | Byte offset into the I/O window |
| io_addr | output | IO_AW (16) | Remapped I/O-space address |

## Verification
The remapping runs every cycle, and a write to the map-type port can land in the same cycle. The bench holds a fixed window offset across such a write. It checks that `io_addr` still shows the old mode just before the edge and the new mode just after it. A read of 0x81C is also issued in the same cycle as a write to 0x81C. The read must return the old nibble before the edge and the new nibble after it. Random traffic over the decoded, undecoded and unclaimed ports is compared with a model in the bench.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [15:0] P_CTL92   = 16'h0092;
  localparam logic [15:0] P_CPUCFG  = 16'h0800;
  localparam logic [15:0] P_FEAT    = 16'h0802;
  localparam logic [15:0] P_BSTAT   = 16'h0803;
  localparam logic [15:0] P_ACT     = 16'h0808;
  localparam logic [15:0] P_EQUIP   = 16'h080C;
  localparam logic [15:0] P_LOCK1   = 16'h0810;
  localparam logic [15:0] P_LOCK2   = 16'h0812;
  localparam logic [15:0] P_FLUSH   = 16'h0814;
  localparam logic [15:0] P_KEY     = 16'h0818;
  localparam logic [15:0] P_SCTL    = 16'h081C;
  localparam logic [15:0] P_L2ID    = 16'h0823;
  localparam logic [15:0] P_MAP     = 16'h0850;
  localparam logic [15:0] P_WIN_LO  = 16'h0800;
  localparam logic [15:0] P_WIN_HI  = 16'h0851;

  localparam int unsigned SCTL_W = 4;

  typedef enum logic [3:0] {
    K_NONE,    // not claimed by this block
    K_CTL92,   // reset / endian control
    K_IDENT,   // fixed byte, writes dropped silently
    K_STATUS,  // fixed byte, writes flagged as errors
    K_ACT,     // activity light, write only
    K_LOCK1,   // fixed byte on read, pulse on write
    K_LOCK2,   // pulse on write, reads 0xFF
    K_FLUSH,   // write accepted with no effect, reads 0xFF
    K_SCTL,    // 4-bit control nibble
    K_MAP,     // window map-type bit
    K_UNDEF    // inside the window but not decoded
  } port_kind_e;

  function automatic port_kind_e classify(input logic [15:0] a);
    if (a == P_CTL92) return K_CTL92;
    if (a < P_WIN_LO || a > P_WIN_HI) return K_NONE;
    case (a)
      P_CPUCFG, P_FEAT, P_BSTAT: return K_IDENT;
      P_EQUIP, P_KEY, P_L2ID:    return K_STATUS;
      P_ACT:                     return K_ACT;
      P_LOCK1:                   return K_LOCK1;
      P_LOCK2:                   return K_LOCK2;
      P_FLUSH:                   return K_FLUSH;
      P_SCTL:                    return K_SCTL;
      P_MAP:                     return K_MAP;
      default:                   return K_UNDEF;
    endcase
  endfunction

  function automatic logic [7:0] fixed_byte(input logic [15:0] a);
    case (a)
      P_CPUCFG: return 8'hEF;
      P_FEAT:   return 8'hAD;
      P_BSTAT:  return 8'hE0;
      P_EQUIP:  return 8'h3C;
      P_LOCK1:  return 8'h39;
      P_KEY:    return 8'h00;
      P_L2ID:   return 8'h03;
      default:  return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned PORT_AW = 16
) (
  input  logic               wr_en,
  input  logic [PORT_AW-1:0] port_addr,
  output logic [15:0]        addr16,
  output port_kind_e         kind,
  output logic               wr_ctl92,
  output logic               wr_act,
  output logic               wr_lock1,
  output logic               wr_lock2,
  output logic               wr_sctl,
  output logic               wr_map,
  output logic               wr_bad
);

  logic upper_zero;

  generate
    if (PORT_AW > 16) begin : g_wide
      assign upper_zero = ~|port_addr[PORT_AW-1:16];
      assign addr16     = port_addr[15:0];
    end else begin : g_narrow
      assign upper_zero = 1'b1;
      assign addr16     = 16'(port_addr);
    end
  endgenerate

  assign kind = upper_zero ? classify(addr16) : K_NONE;

  always_comb begin
    wr_ctl92 = wr_en && (kind == K_CTL92);
    wr_act   = wr_en && (kind == K_ACT);
    wr_lock1 = wr_en && (kind == K_LOCK1);
    wr_lock2 = wr_en && (kind == K_LOCK2);
    wr_sctl  = wr_en && (kind == K_SCTL);
    wr_map   = wr_en && (kind == K_MAP);
    wr_bad   = wr_en && ((kind == K_UNDEF) || (kind == K_STATUS));
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        wr_data,
  input  logic              wr_ctl92,
  input  logic              wr_act,
  input  logic              wr_lock1,
  input  logic              wr_lock2,
  input  logic              wr_sctl,
  input  logic              wr_map,
  input  logic              wr_bad,
  output logic              soft_reset_q,
  output logic              le_mode_q,
  output logic              activity_q,
  output logic [SCTL_W-1:0] sctl_q,
  output logic              map_q,
  output logic              lock1_q,
  output logic              lock2_q,
  output logic              err_q
);

  logic unused_hi;
  assign unused_hi = ^wr_data[7:SCTL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_reset_q <= 1'b0;
      le_mode_q    <= 1'b0;
      activity_q   <= 1'b0;
      sctl_q       <= '0;
      map_q        <= 1'b0;
      lock1_q      <= 1'b0;
      lock2_q      <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      if (wr_ctl92) begin
        soft_reset_q <= wr_data[0];
        le_mode_q    <= wr_data[1];
      end
      if (wr_act)  activity_q <= wr_data[0];
      if (wr_sctl) sctl_q     <= wr_data[SCTL_W-1:0];
      if (wr_map)  map_q      <= wr_data[0];
      lock1_q <= wr_lock1;
      lock2_q <= wr_lock2;
      err_q   <= wr_bad;
    end
  end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic              rd_en,
  input  logic [15:0]       addr16,
  input  port_kind_e        kind,
  input  logic [SCTL_W-1:0] sctl_q,
  input  logic              map_q,
  output logic [7:0]        rd_data
);

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (kind)
        K_NONE, K_CTL92:           rd_data = 8'h00;
        K_IDENT, K_STATUS, K_LOCK1: rd_data = fixed_byte(addr16);
        K_SCTL:                    rd_data = {{(8-SCTL_W){1'b0}}, sctl_q};
        K_MAP:                     rd_data = {7'b0, map_q};
        default:                   rd_data = 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_xlat.sv
module sysctl_xlat #(
  parameter int unsigned WIN_AW   = 23,
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned LOW_KEEP = 5,
  parameter int unsigned PAGE_LSB = 12
) (
  input  logic              sparse,
  input  logic [WIN_AW-1:0] win_offset,
  output logic [IO_AW-1:0]  io_addr
);

  localparam int unsigned HI_W = IO_AW - LOW_KEEP;

  function automatic logic [IO_AW-1:0] flat_map(input logic [WIN_AW-1:0] off);
    return off[IO_AW-1:0];
  endfunction

  function automatic logic [IO_AW-1:0] sparse_map(input logic [WIN_AW-1:0] off);
    return {off[PAGE_LSB+HI_W-1:PAGE_LSB], off[LOW_KEEP-1:0]};
  endfunction

  assign io_addr = sparse ? sparse_map(win_offset) : flat_map(win_offset);

endmodule

// File: rtl/sysctl_port_block.sv
module sysctl_port_block
  import sysctl_pkg::*;
#(
  parameter int unsigned PORT_AW = 16,
  parameter int unsigned WIN_AW  = 23,
  parameter int unsigned IO_AW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [PORT_AW-1:0] port_addr,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic               soft_reset_o,
  output logic               le_mode_o,
  output logic               activity_o,
  output logic               lock1_pulse_o,
  output logic               lock2_pulse_o,
  output logic               wr_err_o,
  input  logic [WIN_AW-1:0]  win_offset,
  output logic [IO_AW-1:0]   io_addr
);

  localparam int unsigned LOW_KEEP = 5;
  localparam int unsigned PAGE_LSB = 12;

  logic [15:0]       addr16;
  port_kind_e        kind;
  logic              wr_ctl92, wr_act, wr_lock1, wr_lock2, wr_sctl, wr_map, wr_bad;
  logic [SCTL_W-1:0] sctl_q;
  logic              map_q;

  sysctl_decode #(.PORT_AW(PORT_AW)) u_dec (
    .wr_en    (wr_en),
    .port_addr(port_addr),
    .addr16   (addr16),
    .kind     (kind),
    .wr_ctl92 (wr_ctl92),
    .wr_act   (wr_act),
    .wr_lock1 (wr_lock1),
    .wr_lock2 (wr_lock2),
    .wr_sctl  (wr_sctl),
    .wr_map   (wr_map),
    .wr_bad   (wr_bad)
  );

  sysctl_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_data     (wr_data),
    .wr_ctl92    (wr_ctl92),
    .wr_act      (wr_act),
    .wr_lock1    (wr_lock1),
    .wr_lock2    (wr_lock2),
    .wr_sctl     (wr_sctl),
    .wr_map      (wr_map),
    .wr_bad      (wr_bad),
    .soft_reset_q(soft_reset_o),
    .le_mode_q   (le_mode_o),
    .activity_q  (activity_o),
    .sctl_q      (sctl_q),
    .map_q       (map_q),
    .lock1_q     (lock1_pulse_o),
    .lock2_q     (lock2_pulse_o),
    .err_q       (wr_err_o)
  );

  sysctl_rdmux u_rd (
    .rd_en  (rd_en),
    .addr16 (addr16),
    .kind   (kind),
    .sctl_q (sctl_q),
    .map_q  (map_q),
    .rd_data(rd_data)
  );

  sysctl_xlat #(
    .WIN_AW  (WIN_AW),
    .IO_AW   (IO_AW),
    .LOW_KEEP(LOW_KEEP),
    .PAGE_LSB(PAGE_LSB)
  ) u_xlat (
    .sparse    (map_q),
    .win_offset(win_offset),
    .io_addr   (io_addr)
  );

endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk #(
  parameter int unsigned PORT_AW = 16,
  parameter int unsigned WIN_AW  = 23,
  parameter int unsigned IO_AW   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [PORT_AW-1:0] port_addr,
  input logic [7:0]         wr_data,
  input logic [7:0]         rd_data,
  input logic               soft_reset_o,
  input logic               le_mode_o,
  input logic               lock1_pulse_o,
  input logic               lock2_pulse_o,
  input logic               wr_err_o,
  input logic [3:0]         sctl_q,
  input logic               map_q,
  input logic [WIN_AW-1:0]  win_offset,
  input logic [IO_AW-1:0]   io_addr
);

  logic at_92, at_810, at_812, at_81c, at_850;
  assign at_92  = (port_addr == PORT_AW'(16'h0092));
  assign at_810 = (port_addr == PORT_AW'(16'h0810));
  assign at_812 = (port_addr == PORT_AW'(16'h0812));
  assign at_81c = (port_addr == PORT_AW'(16'h081C));
  assign at_850 = (port_addr == PORT_AW'(16'h0850));

  // R2
  ctl92_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && at_92) |-> (soft_reset_o == $past(wr_data[0])) && (le_mode_o == $past(wr_data[1])));

  // R4
  lock1_src_chk: assert property (@(posedge clk) disable iff (rst)
    lock1_pulse_o |-> $past(wr_en && at_810));

  // R4
  lock2_src_chk: assert property (@(posedge clk) disable iff (rst)
    lock2_pulse_o |-> $past(wr_en && at_812));

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err_o |-> $past(wr_en));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lock1_pulse_o, lock2_pulse_o, wr_err_o}));

  // R5
  sctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && at_81c) |-> $stable(sctl_q));

  // R5
  sctl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && at_81c) |-> (rd_data == {4'b0, sctl_q}));

  // R6
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && at_850) |-> $stable(map_q));

  // R12
  xlat_low_chk: assert property (@(posedge clk) disable iff (rst)
    io_addr[4:0] == win_offset[4:0]);

endmodule

bind sysctl_port_block sysctl_port_chk #(
  .PORT_AW(PORT_AW),
  .WIN_AW (WIN_AW),
  .IO_AW  (IO_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .port_addr    (port_addr),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .soft_reset_o (soft_reset_o),
  .le_mode_o    (le_mode_o),
  .lock1_pulse_o(lock1_pulse_o),
  .lock2_pulse_o(lock2_pulse_o),
  .wr_err_o     (wr_err_o),
  .sctl_q       (sctl_q),
  .map_q        (map_q),
  .win_offset   (win_offset),
  .io_addr      (io_addr)
);

// File: tb/sysctl_port_block_test.sv
`timescale 1ns/1ps
module sysctl_port_block_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] port_addr = 16'h0;
  logic [7:0]  wr_data = 8'h0;
  logic [7:0]  rd_data;
  logic        soft_reset_o, le_mode_o, activity_o;
  logic        lock1_pulse_o, lock2_pulse_o, wr_err_o;
  logic [22:0] win_offset = 23'h0;
  logic [15:0] io_addr;

  int checks = 0;
  int fails  = 0;

  logic       m_rst = 1'b0, m_le = 1'b0, m_act = 1'b0, m_map = 1'b0;
  logic [3:0] m_sctl = 4'h0;

  always #2.5 clk = ~clk;

  sysctl_port_block uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .port_addr(port_addr), .wr_data(wr_data), .rd_data(rd_data),
    .soft_reset_o(soft_reset_o), .le_mode_o(le_mode_o), .activity_o(activity_o),
    .lock1_pulse_o(lock1_pulse_o), .lock2_pulse_o(lock2_pulse_o), .wr_err_o(wr_err_o),
    .win_offset(win_offset), .io_addr(io_addr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic in_win(input logic [15:0] a);
    return (a >= 16'h0800) && (a <= 16'h0851);
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (!in_win(a)) return 8'h00;           // R13 (and 0x092 gives 0x00, R2)
    case (a)
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'h0, m_sctl};
      16'h0850: return {7'h0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic exp_err(input logic [15:0] a);
    if (!in_win(a)) return 1'b0;
    case (a)
      16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h0810,
      16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] exp_xlat(input logic [22:0] off, input logic sp);
    logic [31:0] o;
    o = {9'h0, off};
    if (!sp) return o[15:0];
    return 16'((o & 32'h1F) | ((o >> 7) & 32'hFFE0));
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " R2 soft_reset"}, soft_reset_o, m_rst);
    chk({tag, " R2 le_mode"}, le_mode_o, m_le);
    chk({tag, " R3 activity"}, activity_o, m_act);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    logic e1, e2, ee;
    @(negedge clk);
    port_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    e1 = (a == 16'h0810);
    e2 = (a == 16'h0812);
    ee = exp_err(a);
    if (a == 16'h0092) begin m_rst = d[0]; m_le = d[1]; end
    if (a == 16'h0808) m_act = d[0];
    if (a == 16'h081C) m_sctl = d[3:0];
    if (a == 16'h0850) m_map = d[0];
    chk("R4 lock1 pulse", lock1_pulse_o, e1);
    chk("R4 lock2 pulse", lock2_pulse_o, e2);
    chk("R10 err flag", wr_err_o, ee);
    check_state("after write");
    @(posedge clk);
    #1;
    chk("R4 pulses one cycle", {lock1_pulse_o, lock2_pulse_o}, 2'b00);
    chk("R10 err one cycle", wr_err_o, 1'b0);
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    @(negedge clk);
    port_addr = a; rd_en = 1'b1;
    #1;
    chk(tag, rd_data, exp_read(a));
    rd_en = 1'b0;
  endtask

  task automatic do_xlat(input logic [22:0] off);
    @(negedge clk);
    win_offset = off;
    #1;
    chk(m_map ? "R12 sparse xlat" : "R11 flat xlat", io_addr, exp_xlat(off, m_map));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  logic [15:0] plist [16] = '{16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h080C,
                              16'h0810, 16'h0812, 16'h0814, 16'h0818, 16'h081C, 16'h0823,
                              16'h0850, 16'h0851, 16'h0804, 16'h0900};

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs after reset
    chk("R1 soft_reset", soft_reset_o, 1'b0);
    chk("R1 le_mode", le_mode_o, 1'b0);
    chk("R1 activity", activity_o, 1'b0);
    chk("R1 pulses", {lock1_pulse_o, lock2_pulse_o, wr_err_o}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    do_read(16'h081C, "R1 sctl cleared");
    do_read(16'h0850, "R1 map cleared");
    do_xlat(23'h7F_F0AB);

    // R2
    do_write(16'h0092, 8'h03);
    do_read(16'h0092, "R2 read 092");
    do_write(16'h0092, 8'h02);
    do_write(16'h0092, 8'h01);
    // R3
    do_write(16'h0808, 8'hFE);
    do_write(16'h0808, 8'h01);
    // R4
    do_write(16'h0810, 8'h00);
    do_write(16'h0812, 8'hA5);
    // R5
    do_write(16'h081C, 8'hFA);
    do_read(16'h081C, "R5 sctl readback");
    // R7
    foreach (plist[i]) do_read(plist[i], "R7/R8/R13 read map");
    // R9: ignored writes
    do_write(16'h0800, 8'h00);
    do_write(16'h0803, 8'hFF);
    do_write(16'h0814, 8'hFF);
    do_read(16'h0800, "R9 ident unchanged");
    do_read(16'h081C, "R9 sctl unchanged");
    // R10
    do_write(16'h0851, 8'hFF);
    do_write(16'h0823, 8'h00);
    do_read(16'h0850, "R10 map unchanged");
    // R13
    do_write(16'h0900, 8'hFF);
    do_write(16'h0093, 8'h03);
    do_read(16'h0900, "R13 unclaimed read");

    // R12: map write in the same cycle as translation
    @(negedge clk);
    win_offset = 23'h5A_B3D6;
    port_addr = 16'h0850; wr_data = 8'h01; wr_en = 1'b1;
    #1;
    chk("R12 old mode before edge", io_addr, exp_xlat(23'h5A_B3D6, 1'b0));
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m_map = 1'b1;
    chk("R12 new mode after edge", io_addr, exp_xlat(23'h5A_B3D6, 1'b1));
    do_read(16'h0850, "R6 map readback");

    // R5: read and write of 0x81C in one cycle
    @(negedge clk);
    port_addr = 16'h081C; wr_data = 8'h05; wr_en = 1'b1; rd_en = 1'b1;
    #1;
    chk("R5 old nibble before edge", rd_data, {4'h0, m_sctl});
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m_sctl = 4'h5;
    chk("R5 new nibble after edge", rd_data, 8'h05);
    rd_en = 1'b0;

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int unsigned op;
      logic [15:0] a;
      op = $urandom_range(0, 5);
      if ($urandom_range(0, 3) == 0) a = 16'h07F8 + 16'($urandom_range(0, 100));
      else a = plist[$urandom_range(0, 15)];
      case (op)
        0, 1: do_write(a, 8'($urandom));
        2, 3: do_read(a, "R7/R8 random read");
        4:    do_xlat(23'($urandom));
        default: do_write(16'h0850, 8'($urandom));
      endcase
    end
    check_state("final");

    summary();
    $finish;
  end

endmodule